// File: doc/BRIEF.md
# Bus-Paced Response Bit Shifter

This block sends a sensor's response word back to a bus master one bit at a time, by switching a current sink on or off. It has no bit clock of its own. The master's three-level signalling sets the pace: a level detector reports each sample of the bus as idle, high or low, and the block moves to the next bit on every high-to-low step. A `1` bit turns the sink on and a `0` bit leaves it off.

A return of the bus to idle ends the response. Idle also gates the sink off in the same cycle, whatever bits are left in the word. The word is loaded in parallel with a strobe, and the strobe is accepted only while the bus is idle. Bits leave most significant first. Once every bit has been sent, further falling steps send zeros. The word never wraps around.

Top module: `bus_paced_resp_shifter`

## Requirements
- R1: Reset gives `sink_en` = 0, `done` = 0, a loaded word of all zeros and a bit count of zero.
- R2: The level code on `bus_lvl` is 2'b00 = idle, 2'b01 = low, 2'b10 = high, and 2'b11 is handled as idle. After idle, a sample at high followed by a sample at low presents the word's most significant bit. It is registered on the clock edge that samples the low level.
- R3: Each later high-to-low step presents the next lower bit (most significant first). The presented bit holds through the low and high phases until the next high-to-low step.
- R4: While the bus is not idle, a presented bit of 1 drives `sink_en` high and a presented bit of 0 drives it low.
- R5: Whenever `bus_lvl` is idle (2'b00 or 2'b11), `sink_en` is 0 combinationally in that same cycle.
- R6: A return to idle ends the response. The presented bit clears, so `sink_en` stays 0 after the bus leaves idle until the next high-to-low step.
- R7: After WORD_W bits have been presented, `done` is 1. Further high-to-low steps present 0, and the bit count saturates at WORD_W with no wrap.
- R8: `load_strb` sampled while the bus is idle latches `word_in` and resets the bit count to zero, which clears `done`.
- R9: `load_strb` sampled while the bus is low or high has no effect on the stored word or the count.
- R10: A step from idle straight to low, or from low to high, presents no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to sample the level codes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_lvl | input | 2 | Decoded bus level: 00 idle, 01 low, 10 high, 11 idle |
| word_in | input | WORD_W | Parallel response word |
| load_strb | input | 1 | Load request, honoured only while the bus is idle |
| sink_en | output | 1 | Current-sink enable |
| done | output | 1 | All WORD_W bits of the word have been presented |

## Verification
The embedded properties check these on every cycle:
- the sink is off at idle levels, including code 11;
- the presented bit holds between falling steps;
- an idle level clears the presented bit;
- the count stays bounded and gives zeros past the end;
- a load during a transfer leaves the stored state unchanged;
- an idle-time load resets the count.

Only the bench's scenarios can show the most-significant-first order of a full word, and that bits resume correctly after an interrupted response. The same holds for how loads that arrive mid-transfer interleave with real transfers. For those, the bench runs random words and random bit counts against a reference model of the requirements.

// File: rtl/resp_shift_pkg.sv
package resp_shift_pkg;

    typedef enum logic [1:0] {
        LVL_IDLE = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_cls_e;

    // Code 11 is folded into idle.
    function automatic lvl_cls_e classify(input logic [1:0] code);
        case (code)
            2'b01:   return LVL_LOW;
            2'b10:   return LVL_HIGH;
            default: return LVL_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/bus_level_tracker.sv
module bus_level_tracker
    import resp_shift_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_lvl,
    output logic       is_idle,
    output logic       fall
);

    typedef struct packed {
        lvl_cls_e prev;
    } trk_state_t;

    trk_state_t st_d, st_q;
    lvl_cls_e   cls_now;

    always_comb begin
        cls_now  = classify(bus_lvl);
        is_idle  = (cls_now == LVL_IDLE);
        fall     = (st_q.prev == LVL_HIGH) && (cls_now == LVL_LOW);
        st_d     = st_q;
        st_d.prev = cls_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: LVL_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    // A fall is only possible at the port-level low code.
    p_fall_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (bus_lvl == 2'b01));

    // A fall in one cycle rules out a fall in the next.
    p_no_double_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/resp_word_reg.sv
module resp_word_reg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_idle,
    input  logic              fall,
    input  logic              load_strb,
    input  logic [WORD_W-1:0] word_in,
    output logic              next_bit,
    output logic              done
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        next_bit = st_q.word[WORD_W-1];
        done     = (st_q.cnt == CNT_FULL);
        if (is_idle) begin
            if (load_strb) begin
                st_d.word = word_in;
                st_d.cnt  = '0;
            end
        end else if (fall) begin
            // Zero fill: no wrap once the word is used up.
            st_d.word = {st_q.word[WORD_W-2:0], 1'b0};
            if (st_q.cnt != CNT_FULL) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);

    p_spent_word_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st_q.word == '0));

    p_busy_load_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strb && !is_idle && !fall) |=> ($stable(st_q.word) && $stable(st_q.cnt)));

    p_idle_load_rewinds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strb && is_idle) |=> (st_q.cnt == '0));

endmodule

// File: rtl/bus_paced_resp_shifter.sv
module bus_paced_resp_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_lvl,
    input  logic [WORD_W-1:0] word_in,
    input  logic              load_strb,
    output logic              sink_en,
    output logic              done
);

    typedef struct packed {
        logic bit_on;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       is_idle;
    logic       fall;
    logic       next_bit;

    bus_level_tracker u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_lvl (bus_lvl),
        .is_idle (is_idle),
        .fall    (fall)
    );

    resp_word_reg #(.WORD_W(WORD_W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_idle   (is_idle),
        .fall      (fall),
        .load_strb (load_strb),
        .word_in   (word_in),
        .next_bit  (next_bit),
        .done      (done)
    );

    always_comb begin
        st_d = st_q;
        if (is_idle) begin
            st_d.bit_on = 1'b0;
        end else if (fall) begin
            st_d.bit_on = next_bit;
        end
        // Idle cuts the sink immediately.
        sink_en = st_q.bit_on && !is_idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_idle_sink_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_lvl == 2'b00) || (bus_lvl == 2'b11)) |-> !sink_en);

    p_hold_between_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !is_idle) |=> $stable(st_q.bit_on));

    p_idle_ends_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |=> !st_q.bit_on);

    p_zero_past_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fall) |=> !st_q.bit_on);

endmodule

// File: tb/bus_paced_resp_shifter_bench.sv
module bus_paced_resp_shifter_bench;

    localparam int  WORD_W   = 8;
    localparam time CLK_PER  = 10ns;
    localparam int  WD_LIMIT = 150000;

    localparam logic [1:0] C_IDLE = 2'b00;
    localparam logic [1:0] C_LOW  = 2'b01;
    localparam logic [1:0] C_HIGH = 2'b10;
    localparam logic [1:0] C_ALT  = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        bus_lvl = C_IDLE;
    logic [WORD_W-1:0] word_in = '0;
    logic              load_strb = 1'b0;
    logic              sink_en;
    logic              done;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model state
    logic [WORD_W-1:0] m_word = '0;
    int                m_cnt  = 0;
    logic              m_bit  = 1'b0;
    logic [1:0]        m_prev = C_IDLE;

    always #(CLK_PER/2) clk = ~clk;

    bus_paced_resp_shifter #(.WORD_W(WORD_W)) u_bus_paced_resp_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_lvl   (bus_lvl),
        .word_in   (word_in),
        .load_strb (load_strb),
        .sink_en   (sink_en),
        .done      (done)
    );

    function automatic logic [1:0] cls_of(input logic [1:0] c);
        return (c == C_ALT) ? C_IDLE : c;
    endfunction

    function automatic logic exp_sink(input logic b, input logic [1:0] c);
        return b && (cls_of(c) != C_IDLE);
    endfunction

    function automatic logic exp_done(input int cnt);
        return cnt == WORD_W;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Apply one sample, advance the model at the edge, then compare.
    task automatic step(input logic [1:0] lvl, input logic ld, input logic [WORD_W-1:0] w,
                        input string tag);
        @(negedge clk);
        bus_lvl   = lvl;
        load_strb = ld;
        word_in   = w;
        @(posedge clk);
        if (cls_of(lvl) == C_IDLE) begin
            m_bit = 1'b0;
            if (ld) begin
                m_word = w;
                m_cnt  = 0;
            end
        end else if (cls_of(lvl) == C_LOW && m_prev == C_HIGH) begin
            m_bit  = m_word[WORD_W-1];
            m_word = m_word << 1;
            if (m_cnt < WORD_W) m_cnt++;
        end
        m_prev = cls_of(lvl);
        #(CLK_PER/4);
        check(tag, "sink_en", sink_en, exp_sink(m_bit, lvl));
        check(tag, "done", done, exp_done(m_cnt));
    endtask

    task automatic send_bits(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(C_HIGH, 1'b0, '0, tag);
            step(C_LOW, 1'b0, '0, tag);
        end
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7351);
        repeat (3) @(negedge clk);
        #(CLK_PER/4);
        // R1: reset state visible at the ports
        check("R1", "sink_en", sink_en, 1'b0);
        check("R1", "done", done, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8/R2/R3: load 0xA5, send all bits MSB first
        step(C_IDLE, 1'b1, 8'hA5, "R8");
        step(C_IDLE, 1'b0, '0, "R8");
        step(C_HIGH, 1'b0, '0, "R2");
        step(C_LOW, 1'b0, '0, "R2");
        check("R2", "first bit is MSB", sink_en, 1'b1);
        step(C_HIGH, 1'b0, '0, "R3");
        check("R3", "bit held in high phase", sink_en, 1'b1);
        send_bits(WORD_W - 1, "R3");
        // R7: done, then zeros past the end
        check("R7", "done after full word", done, 1'b1);
        send_bits(3, "R7");
        check("R7", "zero past end", sink_en, 1'b0);

        // R5/R6: reload 0xFF, cut mid-word with idle and with code 11
        step(C_IDLE, 1'b1, 8'hFF, "R8");
        check("R8", "done cleared by load", done, 1'b0);
        send_bits(2, "R4");
        check("R4", "one bit drives sink", sink_en, 1'b1);
        step(C_ALT, 1'b0, '0, "R5");
        check("R5", "code 11 forces off", sink_en, 1'b0);
        step(C_HIGH, 1'b0, '0, "R6");
        check("R6", "off after idle until fall", sink_en, 1'b0);
        step(C_IDLE, 1'b0, '0, "R5");

        // R10: idle straight to low, and low to high, present nothing
        step(C_LOW, 1'b0, '0, "R10");
        check("R10", "no bit from idle->low", sink_en, 1'b0);
        step(C_HIGH, 1'b0, '0, "R10");
        check("R10", "no bit from low->high", sink_en, 1'b0);
        step(C_LOW, 1'b0, '0, "R10");
        check("R10", "next bit after real fall", sink_en, 1'b1);

        // R9: loads during a transfer are ignored
        step(C_HIGH, 1'b1, 8'h00, "R9");
        step(C_LOW, 1'b1, 8'h00, "R9");
        check("R9", "busy load ignored", sink_en, 1'b1);
        send_bits(WORD_W, "R9");
        step(C_IDLE, 1'b0, '0, "R9");

        // Random transactions
        for (int t = 0; t < 300; t++) begin
            int nb;
            step(($urandom % 2) ? C_IDLE : C_ALT, 1'b1, WORD_W'($urandom), "R8");
            if ($urandom % 3 == 0) step(C_IDLE, 1'b0, '0, "R5");
            if ($urandom % 8 == 0) step(C_LOW, 1'b0, '0, "R10");
            nb = int'($urandom % (WORD_W + 3));
            for (int b = 0; b < nb; b++) begin
                int hl = 1 + int'($urandom % 2);
                int ll = 1 + int'($urandom % 2);
                for (int k = 0; k < hl; k++)
                    step(C_HIGH, ($urandom % 6 == 0), WORD_W'($urandom), "R4");
                for (int k = 0; k < ll; k++)
                    step(C_LOW, ($urandom % 6 == 0), WORD_W'($urandom), "R3");
            end
            step(($urandom % 2) ? C_IDLE : C_ALT, 1'b0, '0, "R6");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule